// File: doc/BRIEF.md
# Frame Slot Allocation Table

This block manages the placement of buffered frames inside one frame memory. Requesters never handle physical addresses: every frame is named by three attributes, a delay index (how many frames old it is), a pixel-granularity id and the id of the processing element that produced it. A write request carries the attributes and a pixel count. The block claims a free slot, binds the attributes to it, and hands the slot's base address and the transfer length to the memory address generator. A read request carries only the attributes. The block finds the bound slot and issues its base and stored length. If the memory is busy, the resolved read waits in a small FIFO until the memory is free.

The memory is split into equal slots of a programmable size. The slot count is the memory size divided by the slot size, rounded down and capped at the table capacity. Loading a new slot size walks the table once. The walk recomputes every base address by repeated addition and drops all bindings. A register keeps the most recently found free slot so that a write does not need a search in its own path. Every request takes a fixed 8 cycles: 3 to decode, 3 to look up and 2 to steer the datapath.

Top module: `frame_slot_map`

## Requirements
- R1: During reset, `done`, `gen_valid` and `req_ready` are low. After reset the table is built for `INIT_SIZE`, and `req_ready` rises within `MAX_SLOTS`+3 cycles.
- R2: A write accepted while a slot is free returns `done` with status 0 (ok) exactly 8 clock edges after the accepting edge. In the same cycle it gives `gen_valid` with `gen_write`=1, `gen_base` = (lowest free slot index) × slot size and `gen_len` = min(pixel count, slot size).
- R3: A read whose attributes are bound returns status 0 with `gen_valid`, `gen_write`=0, and the slot's base and stored length, 8 edges after acceptance. This holds when the memory is idle and no read is queued.
- R4: A read whose attributes match no slot returns status 1 (miss) and no `gen_valid`.
- R5: A write when every slot is bound returns status 2 (full) and no `gen_valid`. Existing bindings stay unchanged.
- R6: The number of usable slots is min(`MAX_SLOTS`, floor(`MEM_WORDS`/size)), and a size of 0 gives no slots. Every issued base plus length stays within `MEM_WORDS`.
- R7: A write whose attributes are already bound takes the lowest free slot and releases the old one. Later reads return the new slot, and the old slot is free for the next write.
- R8: A `cfg_load` pulse takes `cfg_size` as the new slot size. It drops `req_ready` on the next cycle, unbinds every slot and recomputes the bases as index × new size.
- R9: A read that resolves while `mem_busy` is high returns status 3 (queued) and no `gen_valid`. Queued reads are issued in arrival order, one per cycle, each on the cycle after an edge that sees `mem_busy` low.
- R11: `req_ready` is low in the cycle after an acceptance, and it is low while the read queue holds `QDEPTH` entries.
- R12: Writes never wait on `mem_busy`. A write is issued together with its `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Pulse: adopt `cfg_size` and rebuild the table |
| cfg_size | input | ADDR_W | New slot size in words |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ts | input | TS_W | Delay index attribute |
| req_gran | input | GR_W | Pixel-granularity attribute |
| req_pe | input | PE_W | Producing element attribute |
| req_len | input | LEN_W | Pixel count (writes) |
| req_ready | output | 1 | Request accepted when high with `req_valid` |
| mem_busy | input | 1 | Frame memory cannot start a read |
| gen_valid | output | 1 | One-cycle command to the address generator |
| gen_write | output | 1 | Command direction |
| gen_base | output | ADDR_W | Physical base address |
| gen_len | output | LEN_W | Transfer length |
| done | output | 1 | One-cycle completion of a request |
| status | output | 2 | 0 ok, 1 miss, 2 full, 3 queued |

## Verification
Completion and the direct command of a request both appear after the eighth rising edge that follows the accepting edge. The bench drives on falling edges and counts eight falling edges from acceptance before it samples. At each of the seven falling edges in between it confirms that `done` and `gen_valid` are still low. Queued reads are checked one falling edge after `mem_busy` drops, and then one per cycle in order. The drop of `req_ready` is sampled at the first falling edge after an acceptance or a `cfg_load` pulse.

// File: rtl/slotmap_pkg.sv
package slotmap_pkg;
  typedef enum logic [1:0] {
    ST_OK     = 2'd0,
    ST_MISS   = 2'd1,
    ST_FULL   = 2'd2,
    ST_QUEUED = 2'd3
  } stat_e;
endpackage

// File: rtl/slot_table.sv
module slot_table #(
  parameter int MEM_WORDS = 1024,
  parameter int MAX_SLOTS = 8,
  parameter int INIT_SIZE = 128,
  parameter int ADDR_W    = 11,
  parameter int LEN_W     = 11,
  parameter int ATTR_W    = 9,
  localparam int IDX_W    = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1,
  localparam int CNT_W    = $clog2(MAX_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rebuild_go,
  input  logic [ADDR_W-1:0] new_size,
  output logic              rebuilding,
  output logic [ADDR_W-1:0] slot_size,
  input  logic [ATTR_W-1:0] look_attr,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx,
  output logic              free_ok,
  output logic [IDX_W-1:0]  free_idx,
  input  logic              bind_en,
  input  logic [IDX_W-1:0]  bind_idx,
  input  logic [ATTR_W-1:0] bind_attr,
  input  logic [LEN_W-1:0]  bind_len,
  input  logic              drop_en,
  input  logic [IDX_W-1:0]  drop_idx,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_base,
  output logic [LEN_W-1:0]  rd_len
);
  localparam int SUM_W = ADDR_W + 1;

  logic [MAX_SLOTS-1:0] used_q;
  logic [ATTR_W-1:0]    tag_q  [MAX_SLOTS];
  logic [LEN_W-1:0]     size_tab_q [MAX_SLOTS];
  logic [ADDR_W-1:0]    base_q [MAX_SLOTS];
  logic [CNT_W-1:0]     count_q, walk_q;
  logic [ADDR_W-1:0]    acc_q, size_q;
  logic                 busy_q;
  logic                 fits;
  logic                 scan_ok;
  logic [IDX_W-1:0]     scan_idx;
  logic                 cache_ok_q;
  logic [IDX_W-1:0]     cache_idx_q;

  assign fits = (size_q != '0) && (walk_q < CNT_W'(MAX_SLOTS)) &&
                (({1'b0, acc_q} + {1'b0, size_q}) <= SUM_W'(MEM_WORDS));

  // control state: occupancy, rebuild walk
  always_ff @(posedge clk) begin
    if (rst) begin
      used_q  <= '0;
      busy_q  <= 1'b1;
      walk_q  <= '0;
      acc_q   <= '0;
      size_q  <= ADDR_W'(INIT_SIZE);
      count_q <= '0;
    end else if (rebuild_go) begin
      used_q  <= '0;
      busy_q  <= 1'b1;
      walk_q  <= '0;
      acc_q   <= '0;
      size_q  <= new_size;
      count_q <= '0;
    end else if (busy_q) begin
      if (fits) begin
        walk_q <= walk_q + 1'b1;
        acc_q  <= acc_q + size_q;
      end else begin
        busy_q  <= 1'b0;
        count_q <= walk_q;
      end
    end else begin
      if (drop_en) used_q[drop_idx] <= 1'b0;
      if (bind_en) used_q[bind_idx] <= 1'b1;
    end
  end

  // table arrays: no reset, single write port each
  always_ff @(posedge clk) begin
    if (!rst && !rebuild_go && busy_q && fits)
      base_q[walk_q[IDX_W-1:0]] <= acc_q;
    if (bind_en) begin
      tag_q[bind_idx]      <= bind_attr;
      size_tab_q[bind_idx] <= bind_len;
    end
  end

  // attribute match: at most one bound slot carries a given tag
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = MAX_SLOTS - 1; i >= 0; i--) begin
      if (used_q[i] && tag_q[i] == look_attr) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  // lowest free slot among the usable ones
  always_comb begin
    scan_ok  = 1'b0;
    scan_idx = '0;
    for (int i = MAX_SLOTS - 1; i >= 0; i--) begin
      if (!used_q[i] && (CNT_W'(i) < count_q)) begin
        scan_ok  = 1'b1;
        scan_idx = IDX_W'(i);
      end
    end
  end

  // cached free slot, refreshed every cycle outside a rebuild
  always_ff @(posedge clk) begin
    if (rst || rebuild_go || busy_q) begin
      cache_ok_q  <= 1'b0;
      cache_idx_q <= '0;
    end else begin
      cache_ok_q  <= scan_ok;
      cache_idx_q <= scan_idx;
    end
  end

  assign free_ok    = cache_ok_q;
  assign free_idx   = cache_idx_q;
  assign rebuilding = busy_q;
  assign slot_size  = size_q;
  assign rd_base    = base_q[rd_idx];
  assign rd_len     = size_tab_q[rd_idx];
endmodule

// File: rtl/read_queue.sv
module read_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 22,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         empty,
  output logic         full
);
  logic [W-1:0]     store_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) store_q[wr_q] <= push_data;
  end

  assign pop_data = store_q[rd_q];
  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/frame_slot_map.sv
module frame_slot_map
  import slotmap_pkg::*;
#(
  parameter int MEM_WORDS = 1024,
  parameter int MAX_SLOTS = 8,
  parameter int INIT_SIZE = 128,
  parameter int TS_W      = 4,
  parameter int GR_W      = 2,
  parameter int PE_W      = 3,
  parameter int QDEPTH    = 4,
  parameter int DEC_CYC   = 3,
  parameter int LOOK_CYC  = 3,
  parameter int ADAPT_CYC = 2,
  localparam int ADDR_W   = $clog2(MEM_WORDS) + 1,
  localparam int LEN_W    = ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_size,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [TS_W-1:0]   req_ts,
  input  logic [GR_W-1:0]   req_gran,
  input  logic [PE_W-1:0]   req_pe,
  input  logic [LEN_W-1:0]  req_len,
  output logic              req_ready,
  input  logic              mem_busy,
  output logic              gen_valid,
  output logic              gen_write,
  output logic [ADDR_W-1:0] gen_base,
  output logic [LEN_W-1:0]  gen_len,
  output logic              done,
  output logic [1:0]        status
);
  localparam int ATTR_W   = TS_W + GR_W + PE_W;
  localparam int IDX_W    = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1;
  localparam int LAT      = DEC_CYC + LOOK_CYC + ADAPT_CYC;
  localparam int LOOK_END = DEC_CYC + LOOK_CYC;
  localparam int TMR_W    = $clog2(LAT + 1);

  // sequencer state
  logic              run_q;
  logic [TMR_W-1:0]  tmr_q;
  logic              wr_q;
  logic [ATTR_W-1:0] attr_q;
  logic [LEN_W-1:0]  len_q;
  logic              hit_q, free_ok_q;
  logic [IDX_W-1:0]  hit_idx_q, free_idx_q;
  logic              cfg_pend_q;
  logic [ADDR_W-1:0] cfg_size_q;

  // table side
  logic              tab_busy, tab_hit, tab_free_ok;
  logic [IDX_W-1:0]  tab_hit_idx, tab_free_idx, rd_idx;
  logic [ADDR_W-1:0] tab_size, rd_base;
  logic [LEN_W-1:0]  rd_len, wr_len;

  // queue side
  logic              q_empty, q_full, q_push, q_pop;
  logic [ADDR_W+LEN_W-1:0] q_out;

  logic accept, commit, rebuild_go, bind_en, drop_en, direct_rd;

  assign req_ready  = !run_q && !tab_busy && !q_full && !cfg_pend_q;
  assign accept     = req_valid && req_ready && !cfg_load;
  assign commit     = run_q && (tmr_q == TMR_W'(LAT));
  assign rebuild_go = !run_q && (cfg_load || cfg_pend_q);

  assign wr_len    = (len_q > tab_size) ? tab_size : len_q;
  assign rd_idx    = wr_q ? free_idx_q : hit_idx_q;
  assign bind_en   = commit && wr_q && free_ok_q;
  assign drop_en   = bind_en && hit_q;
  assign q_push    = commit && !wr_q && hit_q && (mem_busy || !q_empty);
  assign direct_rd = commit && !wr_q && hit_q && !mem_busy && q_empty;
  assign q_pop     = !commit && !q_empty && !mem_busy;

  slot_table #(
    .MEM_WORDS(MEM_WORDS), .MAX_SLOTS(MAX_SLOTS), .INIT_SIZE(INIT_SIZE),
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .ATTR_W(ATTR_W)
  ) table_i (
    .clk(clk), .rst(rst),
    .rebuild_go(rebuild_go),
    .new_size(cfg_load ? cfg_size : cfg_size_q),
    .rebuilding(tab_busy), .slot_size(tab_size),
    .look_attr(attr_q), .hit(tab_hit), .hit_idx(tab_hit_idx),
    .free_ok(tab_free_ok), .free_idx(tab_free_idx),
    .bind_en(bind_en), .bind_idx(free_idx_q), .bind_attr(attr_q), .bind_len(wr_len),
    .drop_en(drop_en), .drop_idx(hit_idx_q),
    .rd_idx(rd_idx), .rd_base(rd_base), .rd_len(rd_len)
  );

  read_queue #(.DEPTH(QDEPTH), .W(ADDR_W + LEN_W)) rdq_i (
    .clk(clk), .rst(rst),
    .push(q_push), .push_data({rd_base, rd_len}),
    .pop(q_pop), .pop_data(q_out),
    .empty(q_empty), .full(q_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q      <= 1'b0;
      tmr_q      <= '0;
      wr_q       <= 1'b0;
      attr_q     <= '0;
      len_q      <= '0;
      hit_q      <= 1'b0;
      hit_idx_q  <= '0;
      free_ok_q  <= 1'b0;
      free_idx_q <= '0;
      cfg_pend_q <= 1'b0;
      cfg_size_q <= ADDR_W'(INIT_SIZE);
      gen_valid  <= 1'b0;
      gen_write  <= 1'b0;
      gen_base   <= '0;
      gen_len    <= '0;
      done       <= 1'b0;
      status     <= ST_OK;
    end else begin
      gen_valid <= 1'b0;
      done      <= 1'b0;

      if (cfg_load) cfg_size_q <= cfg_size;
      if (cfg_load && run_q) cfg_pend_q <= 1'b1;
      else if (rebuild_go)   cfg_pend_q <= 1'b0;

      if (accept) begin
        run_q  <= 1'b1;
        tmr_q  <= TMR_W'(1);
        wr_q   <= req_write;
        attr_q <= {req_ts, req_gran, req_pe};
        len_q  <= req_len;
      end else if (run_q) begin
        if (tmr_q == TMR_W'(LOOK_END)) begin
          hit_q      <= tab_hit;
          hit_idx_q  <= tab_hit_idx;
          free_ok_q  <= tab_free_ok;
          free_idx_q <= tab_free_idx;
        end
        if (commit) begin
          run_q <= 1'b0;
          tmr_q <= '0;
          done  <= 1'b1;
          if (wr_q) begin
            if (free_ok_q) begin
              status    <= ST_OK;
              gen_valid <= 1'b1;
              gen_write <= 1'b1;
              gen_base  <= rd_base;
              gen_len   <= wr_len;
            end else begin
              status <= ST_FULL;
            end
          end else if (!hit_q) begin
            status <= ST_MISS;
          end else if (direct_rd) begin
            status    <= ST_OK;
            gen_valid <= 1'b1;
            gen_write <= 1'b0;
            gen_base  <= rd_base;
            gen_len   <= rd_len;
          end else begin
            status <= ST_QUEUED;
          end
        end else begin
          tmr_q <= tmr_q + 1'b1;
        end
      end

      if (q_pop) begin
        gen_valid <= 1'b1;
        gen_write <= 1'b0;
        gen_base  <= q_out[ADDR_W+LEN_W-1:LEN_W];
        gen_len   <= q_out[LEN_W-1:0];
      end
    end
  end
endmodule

// File: rtl/frame_slot_map_chk.sv
module frame_slot_map_chk #(
  parameter int MEM_WORDS = 1024,
  parameter int ADDR_W    = 11,
  parameter int LEN_W     = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              mem_busy,
  input logic              gen_valid,
  input logic              gen_write,
  input logic [ADDR_W-1:0] gen_base,
  input logic [LEN_W-1:0]  gen_len,
  input logic              done,
  input logic [1:0]        status
);
  // R11
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  // R4
  miss_no_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (done && status == 2'd1) |-> !gen_valid);
  // R5
  full_no_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (done && status == 2'd2) |-> !gen_valid);
  // R9
  queued_no_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (done && status == 2'd3) |-> !gen_valid);
  // R9
  read_after_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (gen_valid && !gen_write) |-> $past(!mem_busy));
  // R12
  write_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    (gen_valid && gen_write) |-> (done && status == 2'd0));
  // R6
  cmd_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    gen_valid |-> (({1'b0, gen_base} + {1'b0, gen_len}) <= (ADDR_W+1)'(MEM_WORDS)));
  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind frame_slot_map frame_slot_map_chk #(
  .MEM_WORDS(MEM_WORDS), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .mem_busy(mem_busy), .gen_valid(gen_valid), .gen_write(gen_write),
  .gen_base(gen_base), .gen_len(gen_len), .done(done), .status(status)
);

// File: tb/frame_slot_map_tb_top.sv
module frame_slot_map_tb_top;
  localparam int MEM_WORDS = 1024;
  localparam int MAX_SLOTS = 8;
  localparam int INIT_SIZE = 128;
  localparam int QDEPTH    = 4;
  localparam int ADDR_W    = $clog2(MEM_WORDS) + 1;
  localparam int LEN_W     = ADDR_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_load = 1'b0;
  logic [ADDR_W-1:0] cfg_size = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [3:0] req_ts = '0;
  logic [1:0] req_gran = '0;
  logic [2:0] req_pe = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic req_ready;
  logic mem_busy = 1'b0;
  logic gen_valid, gen_write, done;
  logic [ADDR_W-1:0] gen_base;
  logic [LEN_W-1:0] gen_len;
  logic [1:0] status;

  always #2 clk = ~clk;

  frame_slot_map #(.MEM_WORDS(MEM_WORDS), .MAX_SLOTS(MAX_SLOTS),
                   .INIT_SIZE(INIT_SIZE), .QDEPTH(QDEPTH)) dut_i (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_size(cfg_size),
    .req_valid(req_valid), .req_write(req_write), .req_ts(req_ts),
    .req_gran(req_gran), .req_pe(req_pe), .req_len(req_len),
    .req_ready(req_ready), .mem_busy(mem_busy), .gen_valid(gen_valid),
    .gen_write(gen_write), .gen_base(gen_base), .gen_len(gen_len),
    .done(done), .status(status)
  );

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  // reference model
  bit m_used [MAX_SLOTS];
  int m_key  [MAX_SLOTS];
  int m_len  [MAX_SLOTS];
  int m_size = INIT_SIZE;
  int m_count = MAX_SLOTS;
  int qb [QDEPTH];
  int ql [QDEPTH];
  int qn = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int find_match(int key);
    for (int i = 0; i < MAX_SLOTS; i++)
      if (m_used[i] && m_key[i] == key) return i;
    return -1;
  endfunction

  function automatic int find_free();
    for (int i = 0; i < m_count; i++)
      if (!m_used[i]) return i;
    return -1;
  endfunction

  function automatic int slots_for(int sz);
    int c;
    if (sz == 0) return 0;
    c = MEM_WORDS / sz;
    return (c > MAX_SLOTS) ? MAX_SLOTS : c;
  endfunction

  task automatic wait_ready();
    int n = 0;
    while (!req_ready && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic do_req(input bit w, input int ts, input int gr, input int pe,
                        input int len, input string tag);
    int key, m, f, e_stat, e_base, e_len;
    bit e_gen, early;
    key = ts * 64 + gr * 8 + pe;
    m = find_match(key);
    f = find_free();
    e_gen = 0; e_base = 0; e_len = 0;
    if (w) begin
      if (f < 0) e_stat = 2;
      else begin
        e_stat = 0; e_gen = 1;
        e_base = f * m_size;
        e_len  = (len > m_size) ? m_size : len;
        m_used[f] = 1; m_key[f] = key; m_len[f] = e_len;
        if (m >= 0) m_used[m] = 0;
      end
    end else if (m < 0) begin
      e_stat = 1;
    end else if (mem_busy || qn > 0) begin
      e_stat = 3;
      qb[qn] = m * m_size; ql[qn] = m_len[m]; qn++;
    end else begin
      e_stat = 0; e_gen = 1; e_base = m * m_size; e_len = m_len[m];
    end
    wait_ready();
    req_valid = 1; req_write = w;
    req_ts = 4'(ts); req_gran = 2'(gr); req_pe = 3'(pe); req_len = LEN_W'(len);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 0, "R11", "ready after accept", req_ready, 0);
    early = 0;
    for (int k = 1; k < 8; k++) begin
      @(negedge clk);
      if (done || gen_valid) early = 1;
    end
    chk(!early, tag, "early done/cmd", early, 0);
    @(negedge clk);
    chk(done == 1, tag, "done", done, 1);
    chk(status == 2'(e_stat), tag, "status", status, e_stat);
    chk(gen_valid == e_gen, tag, "gen_valid", gen_valid, e_gen);
    if (e_gen) begin
      chk(gen_write == w, tag, "gen_write", gen_write, w);
      chk(gen_base == ADDR_W'(e_base), tag, "gen_base", gen_base, e_base);
      chk(gen_len == LEN_W'(e_len), tag, "gen_len", gen_len, e_len);
    end
  endtask

  task automatic set_size(input int sz);
    wait_ready();
    cfg_size = ADDR_W'(sz);
    cfg_load = 1;
    @(negedge clk);
    cfg_load = 0;
    chk(req_ready == 0, "R8", "ready during rebuild", req_ready, 0);
    for (int i = 0; i < MAX_SLOTS; i++) m_used[i] = 0;
    m_size = sz;
    m_count = slots_for(sz);
    wait_ready();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int waited;
    void'($urandom(32'd4711));
    for (int i = 0; i < MAX_SLOTS; i++) m_used[i] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(done == 0 && gen_valid == 0, "R1", "outputs in reset", {done, gen_valid}, 0);
    chk(req_ready == 0, "R1", "ready in reset", req_ready, 0);
    rst = 0;
    waited = 0;
    while (!req_ready && waited < MAX_SLOTS + 3) begin
      @(negedge clk);
      waited++;
    end
    chk(req_ready == 1, "R1", "ready after build", req_ready, 1);

    // R2 writes, clamp, lowest free slot
    do_req(1, 1, 0, 1, 50, "R2");
    do_req(1, 2, 1, 0, 500, "R2");
    // R3 read hits
    do_req(0, 1, 0, 1, 0, "R3");
    do_req(0, 2, 1, 0, 0, "R3");
    // R4 miss
    do_req(0, 7, 3, 7, 0, "R4");
    // R7 rebind existing attributes
    do_req(1, 1, 0, 1, 60, "R7");
    do_req(0, 1, 0, 1, 0, "R7");
    do_req(1, 3, 0, 0, 10, "R7");

    // random mix
    for (int n = 0; n < 60; n++) begin
      bit w;
      w = ($urandom_range(0, 1) == 1);
      do_req(w, $urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 1),
             $urandom_range(1, 200), w ? "R2" : "R3");
    end

    // R8 / R6: new size 300 -> 3 slots
    set_size(300);
    do_req(0, 2, 1, 0, 0, "R8");
    do_req(1, 0, 0, 0, 300, "R8");
    do_req(1, 0, 0, 1, 20, "R6");
    do_req(1, 0, 1, 0, 999, "R6");
    do_req(1, 0, 1, 1, 5, "R5");
    do_req(0, 0, 0, 0, 0, "R5");
    // R6 size 0 -> no slots
    set_size(0);
    do_req(1, 1, 1, 1, 5, "R6");

    // R12 / R9 / R11 queue behaviour
    set_size(128);
    do_req(1, 5, 0, 0, 40, "R2");
    do_req(1, 6, 0, 0, 70, "R2");
    mem_busy = 1;
    do_req(1, 7, 0, 0, 90, "R12");
    do_req(0, 5, 0, 0, 0, "R9");
    do_req(0, 6, 0, 0, 0, "R9");
    do_req(0, 7, 0, 0, 0, "R9");
    do_req(0, 5, 0, 0, 0, "R9");
    chk(req_ready == 0, "R11", "ready with full queue", req_ready, 0);
    repeat (3) begin
      @(negedge clk);
      chk(gen_valid == 0, "R9", "no cmd while busy", gen_valid, 0);
    end
    mem_busy = 0;
    for (int i = 0; i < qn; i++) begin
      @(negedge clk);
      chk(gen_valid == 1 && gen_write == 0, "R9", "queued read issued", gen_valid, 1);
      chk(gen_base == ADDR_W'(qb[i]), "R9", "queued base", gen_base, qb[i]);
      chk(gen_len == LEN_W'(ql[i]), "R9", "queued len", gen_len, ql[i]);
    end
    qn = 0;
    @(negedge clk);
    chk(gen_valid == 0, "R9", "queue drained", gen_valid, 0);
    chk(req_ready == 1, "R11", "ready after drain", req_ready, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule